// File: doc/BRIEF.md
# Sound Channel Length Timer

This block is the length timer for one voice of a sound generator. Software writes a length register, which loads a negated step count. It also writes a control register that holds a trigger bit and a length-enable bit. An external frame sequencer delivers a one-cycle length step pulse and a flag that marks the first half of the length period. The block keeps the remaining length and a channel-enable flag. The flag is set by a trigger when the converter is powered, and it is cleared when the count runs out.

A write to the control register can decrement the count by itself. This happens when the length-enable goes from off to on during the first half of the period. A count that has reached zero stays frozen at zero until a trigger reloads it to the maximum. The reload is decremented once more if length-enable is set and the sequencer is in the first half. A three-state machine tracks the timer:
- `LC_FROZEN`: the count is zero.
- `LC_HOLD`: the count is nonzero and length-enable is off.
- `LC_RUN`: the count is nonzero and length-enable is on.

The machine has the following transitions:
- *reload*: FROZEN to HOLD or RUN, on a trigger.
- *arm*: HOLD to RUN, when the enable is written to 1.
- *disarm*: RUN to HOLD, when the enable is written to 0.
- *expire*: RUN to FROZEN on the last step, or HOLD to FROZEN on an extra decrement from 1 without a trigger.
- *reclock*: HOLD to RUN, when an extra decrement from 1 is combined with a trigger.
- *load*: any state to HOLD or RUN, on a length write.

Top module: `lc_length_timer`

## Requirements
- R1: After reset the remaining length is 0, the channel-enable flag is 0 and length-enable is off.
- R2: A length write of value V (LEN_W = log2(MAX) bits) sets the remaining length to MAX − V. V = 0 gives MAX. The channel-enable flag is not changed.
- R3: In a control write, data bit 7 is the trigger and data bit 6 is the new length-enable. The enable is stored for later steps.
- R4: A step pulse decrements a nonzero length when length-enable is on. Reaching zero clears the channel-enable flag. With length-enable off, a step has no effect.
- R5: A control write that turns length-enable from 0 to 1 while first_half is high decrements a nonzero length once. The same write with first_half low does not.
- R6: Control writes that go from enabled to enabled, from enabled to disabled, or from disabled to disabled never decrement the length.
- R7: If the extra decrement of R5 reaches zero, the channel-enable flag is 0 in the following cycle.
- R8: A zero length stays zero through enable toggles and steps until a trigger or a length write.
- R9: A trigger while the length is zero reloads it to MAX. If the write also sets length-enable and first_half is high, the result is MAX − 1.
- R10: A single write of trigger plus enable (0xC0) to a length of 1 from the disabled state, in the first half, yields MAX − 1 with the channel-enable flag set (dac_en high).
- R11: A trigger on a nonzero length leaves the length unchanged, apart from the R5 decrement.
- R12: A trigger sets the channel-enable flag only when dac_en is high. With dac_en low, the length reload and clocking of R9 still occur.
- R13: A length write in the same cycle as a control write wins, and the control write is dropped. A step in the same cycle as a control write is dropped. The state is LC_FROZEN exactly when the length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr | input | 1 | Length register write strobe |
| len_data | input | LEN_W | Negated length value |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control value: bit 7 trigger, bit 6 length-enable |
| step | input | 1 | Length step pulse from the frame sequencer |
| first_half | input | 1 | High while the sequencer is in the first half of the length period |
| dac_en | input | 1 | Converter power state for this voice |
| length_left | output | CNT_W | Remaining length |
| chan_on | output | 1 | Channel-enable flag |

## Verification
The assertions assume that strobes are single-cycle and synchronous to clk. They also assume that first_half and dac_en are stable within the cycle of a write, and that len_data is meaningful only when len_wr is high. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. Write collisions are created only on purpose, to exercise the R13 priority. Sequencer timing is produced directly by the bench, so the half-period flag can be placed on either side of any write.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic [1:0] {
        LC_FROZEN = 2'd0,
        LC_HOLD   = 2'd1,
        LC_RUN    = 2'd2
    } lc_state_e;

    localparam int CTRL_TRIG_BIT = 7;
    localparam int CTRL_EN_BIT   = 6;

    typedef struct packed {
        logic wr;        // control write that takes effect this cycle
        logic trig;      // trigger requested
        logic en_new;    // length-enable value written
        logic extra;     // off-to-on enable edge in the first half
        logic post_clk;  // reload is followed by one more decrement
    } lc_wr_evt_t;

endpackage

// File: rtl/lc_write_decode.sv
module lc_write_decode
    import lc_pkg::*;
(
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_data,
    input  logic       len_wr,
    input  logic       en_q,
    input  logic       first_half,
    output lc_wr_evt_t evt
);

    always_comb begin
        evt.wr       = ctrl_wr & ~len_wr;
        evt.trig     = evt.wr & ctrl_data[CTRL_TRIG_BIT];
        evt.en_new   = ctrl_data[CTRL_EN_BIT];
        evt.extra    = evt.wr & ~en_q & evt.en_new & first_half;
        evt.post_clk = evt.trig & evt.en_new & first_half;
    end

endmodule

// File: rtl/lc_counter.sv
module lc_counter
    import lc_pkg::*;
#(
    parameter int MAX   = 64,
    parameter int LEN_W = $clog2(MAX),
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_data,
    input  lc_wr_evt_t       evt,
    input  logic             step_ok,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero_hit
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] mid;

    always_comb begin
        cnt_d    = cnt_q;
        mid      = cnt_q;
        zero_hit = 1'b0;
        if (len_wr) begin
            cnt_d = MAX_C - CNT_W'(len_data);
        end else if (evt.wr) begin
            if (evt.extra && cnt_q != '0) begin
                mid      = cnt_q - ONE_C;
                zero_hit = (mid == '0);
            end
            if (evt.trig && mid == '0) begin
                mid = evt.post_clk ? (MAX_C - ONE_C) : MAX_C;
            end
            cnt_d = mid;
        end else if (step_ok && cnt_q != '0) begin
            cnt_d    = cnt_q - ONE_C;
            zero_hit = (cnt_d == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lc_length_timer.sv
module lc_length_timer
    import lc_pkg::*;
#(
    parameter int MAX   = 64,
    parameter int LEN_W = $clog2(MAX),
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_data,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_data,
    input  logic             step,
    input  logic             first_half,
    input  logic             dac_en,
    output logic [CNT_W-1:0] length_left,
    output logic             chan_on
);

    lc_state_e  st_q, st_d;
    lc_wr_evt_t evt;
    logic       en_q;
    logic       zero_hit;
    logic       step_ok;
    logic       at_one;

    lc_write_decode u_dec (
        .ctrl_wr    (ctrl_wr),
        .ctrl_data  (ctrl_data),
        .len_wr     (len_wr),
        .en_q       (en_q),
        .first_half (first_half),
        .evt        (evt)
    );

    assign step_ok = step & ~ctrl_wr & ~len_wr & (st_q == LC_RUN);
    assign at_one  = (length_left == CNT_W'(1));

    lc_counter #(.MAX(MAX), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_wr   (len_wr),
        .len_data (len_data),
        .evt      (evt),
        .step_ok  (step_ok),
        .cnt_q    (length_left),
        .zero_hit (zero_hit)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (len_wr) begin
            st_d = en_q ? LC_RUN : LC_HOLD;                          // load
        end else if (evt.wr) begin
            unique case (st_q)
                LC_FROZEN: if (evt.trig) st_d = evt.en_new ? LC_RUN : LC_HOLD; // reload
                LC_HOLD: begin
                    if (evt.extra && at_one) st_d = evt.trig ? LC_RUN : LC_FROZEN; // reclock / expire
                    else                     st_d = evt.en_new ? LC_RUN : LC_HOLD;  // arm
                end
                LC_RUN:    st_d = evt.en_new ? LC_RUN : LC_HOLD;    // disarm
                default:   st_d = LC_FROZEN;
            endcase
        end else if (step_ok && at_one) begin
            st_d = LC_FROZEN;                                        // expire
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LC_FROZEN;
        else        st_q <= st_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            chan_on <= 1'b0;
        end else begin
            if (evt.wr) en_q <= evt.en_new;
            if (evt.trig && dac_en) chan_on <= 1'b1;
            else if (zero_hit)      chan_on <= 1'b0;
        end
    end

endmodule

// File: rtl/lc_length_timer_chk.sv
module lc_length_timer_chk
    import lc_pkg::*;
#(
    parameter int MAX   = 64,
    parameter int LEN_W = $clog2(MAX),
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             len_wr,
    input logic [LEN_W-1:0] len_data,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_data,
    input logic             step,
    input logic             first_half,
    input logic             dac_en,
    input logic [CNT_W-1:0] length_left,
    input logic             chan_on,
    input logic             en_q,
    input lc_state_e        st_q
);

    // R1
    zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (length_left == '0) |-> !chan_on);

    // R2
    len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr |=> length_left == (CNT_W'(MAX) - CNT_W'($past(len_data))));

    // R4
    step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ctrl_wr && !len_wr && en_q && length_left != '0)
        |=> length_left == $past(length_left) - CNT_W'(1));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (length_left == '0 && !len_wr && !(ctrl_wr && ctrl_data[CTRL_TRIG_BIT]))
        |=> length_left == '0);

    // R11
    trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !len_wr && ctrl_data[CTRL_TRIG_BIT] && length_left > CNT_W'(1)
         && (en_q || !ctrl_data[CTRL_EN_BIT] || !first_half))
        |=> $stable(length_left));

    // R12
    no_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !dac_en && !chan_on) |=> !chan_on);

    // R13
    state_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LC_FROZEN) == (length_left == '0));

    // R13
    step_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_wr && !len_wr && en_q && ctrl_data[CTRL_EN_BIT]
         && !ctrl_data[CTRL_TRIG_BIT]) |=> $stable(length_left));

endmodule

bind lc_length_timer lc_length_timer_chk #(.MAX(MAX), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_wr      (len_wr),
    .len_data    (len_data),
    .ctrl_wr     (ctrl_wr),
    .ctrl_data   (ctrl_data),
    .step        (step),
    .first_half  (first_half),
    .dac_en      (dac_en),
    .length_left (length_left),
    .chan_on     (chan_on),
    .en_q        (en_q),
    .st_q        (st_q)
);

// File: tb/lc_length_timer_tb.sv
`timescale 1ns/1ps
module lc_length_timer_tb;

    localparam int MAX   = 64;
    localparam int LEN_W = $clog2(MAX);
    localparam int CNT_W = $clog2(MAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_data = '0;
    logic             ctrl_wr = 1'b0;
    logic [7:0]       ctrl_data = '0;
    logic             step = 1'b0;
    logic             first_half = 1'b0;
    logic             dac_en = 1'b1;
    logic [CNT_W-1:0] length_left;
    logic             chan_on;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int m_cnt = 0;
    int m_en  = 0;
    int m_on  = 0;

    always #4 clk = ~clk;

    lc_length_timer #(.MAX(MAX)) u_dut (
        .clk (clk), .rst_n (rst_n), .len_wr (len_wr), .len_data (len_data),
        .ctrl_wr (ctrl_wr), .ctrl_data (ctrl_data), .step (step),
        .first_half (first_half), .dac_en (dac_en),
        .length_left (length_left), .chan_on (chan_on)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_en = 0; m_on = 0;
        end else if (len_wr) begin
            m_cnt = MAX - int'(len_data);
        end else if (ctrl_wr) begin
            if (ctrl_data[6] && m_en == 0 && first_half && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_on = 0;
            end
            if (ctrl_data[7]) begin
                if (dac_en) m_on = 1;
                if (m_cnt == 0) m_cnt = (ctrl_data[6] && first_half) ? MAX - 1 : MAX;
            end
            m_en = ctrl_data[6] ? 1 : 0;
        end else if (step && m_en == 1 && m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) m_on = 0;
        end
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (int'(length_left) != m_cnt || int'(chan_on) != m_on) begin
                fails++;
                $display("FAIL R4 model compare: len=%0d on=%0d expected len=%0d on=%0d",
                         length_left, chan_on, m_cnt, m_on);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wlen(input int v);
        @(negedge clk); len_wr = 1'b1; len_data = LEN_W'(v);
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic wctl(input logic [7:0] d);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_data = d;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
    endtask

    initial begin
        #2_000_000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset length", int'(length_left), 0);
        chk("R1 reset flag", int'(chan_on), 0);

        wlen(MAX - 2);
        chk("R2 load -2", int'(length_left), 2);
        chk("R2 flag untouched", int'(chan_on), 0);

        first_half = 1'b0;
        wctl(8'h80);
        chk("R11 trigger keeps length", int'(length_left), 2);
        chk("R12 trigger sets flag", int'(chan_on), 1);
        wctl(8'h40);
        chk("R5 second half no extra", int'(length_left), 2);

        wctl(8'h00);
        wlen(MAX - 2);
        first_half = 1'b1;
        wctl(8'h40);
        chk("R5 first half extra", int'(length_left), 1);
        wctl(8'h40);
        chk("R6 en to en", int'(length_left), 1);
        wctl(8'h00);
        chk("R6 en to dis", int'(length_left), 1);
        wctl(8'h00);
        chk("R6 dis to dis", int'(length_left), 1);
        pulse_step();
        chk("R4 step while disabled", int'(length_left), 1);

        first_half = 1'b0;
        wctl(8'h40);
        chk("R3 enable stored, no extra", int'(length_left), 1);
        pulse_step();
        chk("R4 step to zero", int'(length_left), 0);
        chk("R4 expiry clears flag", int'(chan_on), 0);

        wctl(8'h00);
        first_half = 1'b1;
        wctl(8'h40);
        chk("R8 frozen enable", int'(length_left), 0);
        pulse_step();
        chk("R8 frozen step", int'(length_left), 0);

        wctl(8'h00);
        wctl(8'h80);
        chk("R9 reload max", int'(length_left), MAX);
        first_half = 1'b0;
        wctl(8'h40);
        pulse_step();
        pulse_step();
        chk("R4 two steps", int'(length_left), MAX - 2);

        wctl(8'h00);
        wlen(MAX - 1);
        wctl(8'h80);
        first_half = 1'b1;
        wctl(8'h00);
        wctl(8'h40);
        chk("R7 extra to zero", int'(length_left), 0);
        chk("R7 flag cleared", int'(chan_on), 0);
        wctl(8'hC0);
        chk("R9 reload clocked", int'(length_left), MAX - 1);

        wctl(8'h00);
        wlen(MAX - 1);
        wctl(8'hC0);
        chk("R10 combined write length", int'(length_left), MAX - 1);
        chk("R10 combined write flag", int'(chan_on), 1);

        wctl(8'h00);
        wlen(MAX - 1);
        wctl(8'h40);
        dac_en = 1'b0;
        wctl(8'h80);
        chk("R12 dac off reload", int'(length_left), MAX);
        chk("R12 dac off flag", int'(chan_on), 0);
        dac_en = 1'b1;

        wlen(0);
        chk("R2 zero gives max", int'(length_left), MAX);

        first_half = 1'b0;
        @(negedge clk); step = 1'b1; ctrl_wr = 1'b1; ctrl_data = 8'h40;
        @(negedge clk); step = 1'b0; ctrl_wr = 1'b0;
        chk("R13 step dropped", int'(length_left), MAX);
        @(negedge clk); len_wr = 1'b1; len_data = LEN_W'(MAX - 4);
                        ctrl_wr = 1'b1; ctrl_data = 8'h00;
        @(negedge clk); len_wr = 1'b0; ctrl_wr = 1'b0;
        chk("R13 length write wins", int'(length_left), 4);
        pulse_step();
        chk("R13 control write dropped", int'(length_left), 3);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule